// File: doc/BRIEF.md
# Flash Row Programming Controller

This controller sits between a processor's register bus and an on-chip program flash array. Software fills a 64-word holding buffer with ordinary word loads. The loads must arrive in ascending order and all fall inside one 64-word aligned group. Software then arms the controller with a two-value key and sets the start bit in the control register. The controller then performs one of three operations on the array:

- a row write, which streams the whole buffer into one 192-byte row;
- a page erase, which clears the 1536-byte page that contains the buffered group;
- a word write, which programs the most recently buffered word.

An operation's length is counted in ticks of an on-chip RC oscillator, supplied as a clock-enable pulse (`osc_tick`). While an operation runs, `cpu_stall` holds the processor. The start bit reads back as 1 until the hardware clears it at the end, and a one-cycle `op_done` marks completion. The control register also carries two sticky flags. One reports a buffer load that broke the ordering rules. The other reports a start that was refused.

Control FSM states: `ST_IDLE` (accept loads and register writes), `ST_STREAM` (one buffer word per cycle to the array), `ST_ISSUE` (one-cycle erase or word strobe), `ST_WAIT` (count oscillator ticks), `ST_FINISH` (done pulse, empty the buffer). Its transitions are:

- IDLE→STREAM on an accepted row start.
- IDLE→ISSUE on an accepted erase or word start.
- STREAM→WAIT after the 64th word.
- ISSUE→WAIT.
- WAIT→FINISH when the tick count expires.
- FINISH→IDLE.

Unlock states: `K_IDLE`, `K_HALF` (first key seen), `K_ARMED` (second key seen). Its transitions are:

- A key write with low byte 0x55 goes to HALF from any state.
- A key write with low byte 0xAA goes from HALF to ARMED.
- Any other key write returns to IDLE.
- Any control write returns to IDLE.

Top module: `flashprog_ctrl`

## Requirements
- R1: After reset `ctl_rdata` reads 0x0000, `cpu_stall` is low and no array strobe is active.
- R2: A control write (`reg_sel`=0) with bit 15 set starts an operation only if the two register writes immediately before it were key writes (`reg_sel`=1) with low bytes 0x55 and then 0xAA.
- R3: A start write without that exact unlock is ignored: bit 15 reads 0, `cpu_stall` stays low, no strobe occurs, and the refused-start flag is not set. The disallowed unlocks include a control write between the keys, another value between the keys, and the keys in the wrong order.
- R4: A buffer load whose word address is not the next slot in sequence, or that leaves the group of the first load, sets sticky bit 13 of `ctl_rdata`. A later legal-looking load does not clear the flag. A control write with bit 13 set clears it and empties the buffer.
- R5: An armed start is refused, and sticky bit 12 is set, when any of these holds: bit 13 is set, the row operation is chosen without 64 loaded words, any operation is chosen with an empty buffer, or the op field is 00. A refused start causes no strobe and no stall. Writing 1 to bit 12 clears the flag.
- R6: Op field bits [1:0]=01 selects a row write. It drives `fl_row_prog` for 64 consecutive cycles. The byte address starts at group×192 and steps by 3. The data carries the buffered words in load order.
- R7: Op field 10 selects a page erase. It drives a single-cycle `fl_page_erase` with the byte address of the 1536-byte page containing the buffered group (group with its 3 low bits cleared, times 192).
- R8: Op field 11 selects a word write. It drives a single-cycle `fl_word_prog` with byte address 3× the word address of the last load, and with that load's data.
- R9: While an operation runs, bit 15 reads 1 and `cpu_stall` is high. Both drop after the operation's tick count (`ROW_TICKS`, `PAGE_TICKS` or `WORD_TICKS` ticks) has elapsed. `op_done` pulses for the last stalled cycle.
- R10: At most one array strobe is active in any cycle, and only while `cpu_stall` is high.
- R11: A completed operation empties the buffer, so the next load may start a new group at slot 0 without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the key register |
| reg_wdata | input | 16 | Register write data |
| ctl_rdata | output | 16 | Control register: [15] busy/start, [13] load error, [12] refused start, [1:0] op |
| buf_we | input | 1 | Holding-buffer load strobe |
| buf_waddr | input | WORD_AW | Word address of the load |
| buf_wdata | input | 24 | Instruction word to load |
| osc_tick | input | 1 | One pulse per RC oscillator period |
| cpu_stall | output | 1 | Holds the processor while an operation runs |
| op_done | output | 1 | One-cycle completion pulse |
| fl_addr | output | WORD_AW+2 | Array byte address |
| fl_wdata | output | 24 | Array write data |
| fl_row_prog | output | 1 | Row-program strobe, one per word |
| fl_page_erase | output | 1 | Page-erase strobe |
| fl_word_prog | output | 1 | Single-word program strobe |

## Verification
The main function is tried with four input patterns:

- A full, in-order 64-word buffer written to a row. This tells correct streaming order and alignment apart from off-by-one addressing, because the bytes just before and after the row must stay erased.
- A single word in a row that is not page-aligned, erased as a page. This shows that page alignment is derived from the group and not from the row, with both page edges checked.
- Three words followed by a word write. This separates "last load" from "first load".
- Corrupted unlock sequences and corrupted load orders. These show that both the key sequencer and the buffer rules refuse work rather than partly performing it, and that the stall length tracks the duration chosen for each operation.

// File: rtl/flashprog_pkg.sv
package flashprog_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_STREAM, ST_ISSUE, ST_WAIT, ST_FINISH
    } fp_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00, OP_ROW = 2'b01, OP_PAGE = 2'b10, OP_WORD = 2'b11
    } fp_op_e;

    typedef enum logic [1:0] {
        K_IDLE, K_HALF, K_ARMED
    } fp_key_e;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
    localparam int CTL_BUSY  = 15;
    localparam int CTL_LDERR = 13;
    localparam int CTL_ABORT = 12;
endpackage

// File: rtl/flashprog_unlock.sv
module flashprog_unlock
    import flashprog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic       other_wr,
    input  logic [7:0] key_val,
    output logic       armed
);
    fp_key_e kst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kst <= K_IDLE;
        end else if (key_wr) begin
            if (key_val == KEY_FIRST)
                kst <= K_HALF;
            else if (kst == K_HALF && key_val == KEY_SECOND)
                kst <= K_ARMED;
            else
                kst <= K_IDLE;
        end else if (other_wr) begin
            kst <= K_IDLE;
        end
    end

    assign armed = (kst == K_ARMED);
endmodule

// File: rtl/flashprog_holdbuf.sv
module flashprog_holdbuf #(
    parameter int WORD_AW   = 15,
    parameter int ROW_WORDS = 64,
    parameter int DW        = 24,
    localparam int IW = $clog2(ROW_WORDS),
    localparam int GW = WORD_AW - IW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_en,
    input  logic [WORD_AW-1:0] ld_addr,
    input  logic [DW-1:0]      ld_data,
    input  logic               flush,
    input  logic [IW-1:0]      rd_idx,
    output logic [DW-1:0]      rd_data,
    output logic [IW:0]        count,
    output logic [GW-1:0]      group,
    output logic               load_err
);
    logic [DW-1:0] mem [ROW_WORDS];
    logic in_order;

    assign in_order = (ld_addr[IW-1:0] == count[IW-1:0])
                   && (count != (IW+1)'(ROW_WORDS))
                   && (count == '0 || ld_addr[WORD_AW-1:IW] == group);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            group    <= '0;
            load_err <= 1'b0;
        end else if (flush) begin
            count    <= '0;
            load_err <= 1'b0;
        end else if (ld_en) begin
            if (in_order) begin
                count <= count + 1'b1;
                if (count == '0)
                    group <= ld_addr[WORD_AW-1:IW];
            end else begin
                load_err <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (ld_en && in_order && !flush)
            mem[ld_addr[IW-1:0]] <= ld_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/flashprog_optimer.sv
module flashprog_optimer #(
    parameter int TW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] dur,
    input  logic          tick,
    output logic          expire
);
    logic [TW-1:0] cnt;
    logic          run;

    assign expire = run && tick && (cnt == dur - TW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= '0;
            run <= 1'b1;
        end else if (expire) begin
            run <= 1'b0;
        end else if (run && tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/flashprog_ctrl.sv
module flashprog_ctrl
    import flashprog_pkg::*;
#(
    parameter int WORD_AW    = 15,
    parameter int ROW_WORDS  = 64,
    parameter int PAGE_ROWS  = 8,
    parameter int ROW_TICKS  = 11064,
    parameter int PAGE_TICKS = 9000,
    parameter int WORD_TICKS = 2500
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_sel,
    input  logic [15:0]        reg_wdata,
    output logic [15:0]        ctl_rdata,
    input  logic               buf_we,
    input  logic [WORD_AW-1:0] buf_waddr,
    input  logic [23:0]        buf_wdata,
    input  logic               osc_tick,
    output logic               cpu_stall,
    output logic               op_done,
    output logic [WORD_AW+1:0] fl_addr,
    output logic [23:0]        fl_wdata,
    output logic               fl_row_prog,
    output logic               fl_page_erase,
    output logic               fl_word_prog
);
    localparam int IW   = $clog2(ROW_WORDS);
    localparam int GW   = WORD_AW - IW;
    localparam int PW   = $clog2(PAGE_ROWS);
    localparam int FAW  = WORD_AW + 2;
    localparam int MAXT = (ROW_TICKS > PAGE_TICKS)
                        ? ((ROW_TICKS > WORD_TICKS) ? ROW_TICKS : WORD_TICKS)
                        : ((PAGE_TICKS > WORD_TICKS) ? PAGE_TICKS : WORD_TICKS);
    localparam int TW   = $clog2(MAXT + 1);

    fp_state_e     state;
    fp_op_e        op_q, op_req;
    logic [IW-1:0] idx;
    logic          abort_q;

    logic          ctl_wr, key_wr, key_armed;
    logic          launch_req, op_ok, launch, reject;
    logic          ld_en, flush, wr_flush, fin_flush;
    logic [IW-1:0] rd_idx, last_idx;
    logic [23:0]   rd_data;
    logic [IW:0]   count;
    logic [GW-1:0] group;
    logic          load_err;
    logic          tmr_start, tmr_expire;
    logic [TW-1:0] dur;

    function automatic logic [FAW-1:0] to_byte(input logic [WORD_AW-1:0] w);
        return FAW'(w) + FAW'({w, 1'b0});
    endfunction

    assign ctl_wr     = reg_wr && !reg_sel;
    assign key_wr     = reg_wr && reg_sel;
    assign op_req     = fp_op_e'(reg_wdata[1:0]);
    assign launch_req = ctl_wr && reg_wdata[CTL_BUSY] && key_armed && (state == ST_IDLE);

    always_comb begin
        unique case (op_req)
            OP_ROW:           op_ok = !load_err && (count == (IW+1)'(ROW_WORDS));
            OP_PAGE, OP_WORD: op_ok = !load_err && (count != '0);
            default:          op_ok = 1'b0;
        endcase
    end

    assign launch   = launch_req && op_ok;
    assign reject   = launch_req && !op_ok;
    assign wr_flush = ctl_wr && (state == ST_IDLE) && !launch_req && reg_wdata[CTL_LDERR];
    assign flush    = wr_flush || fin_flush;
    assign ld_en    = buf_we && (state == ST_IDLE);
    assign last_idx = count[IW-1:0] - 1'b1;
    assign rd_idx   = (state == ST_STREAM) ? idx : last_idx;

    always_comb begin
        unique case (op_q)
            OP_ROW:  dur = TW'(ROW_TICKS);
            OP_PAGE: dur = TW'(PAGE_TICKS);
            default: dur = TW'(WORD_TICKS);
        endcase
    end

    flashprog_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .other_wr (ctl_wr),
        .key_val  (reg_wdata[7:0]),
        .armed    (key_armed)
    );

    flashprog_holdbuf #(.WORD_AW(WORD_AW), .ROW_WORDS(ROW_WORDS), .DW(24)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_addr  (buf_waddr),
        .ld_data  (buf_wdata),
        .flush    (flush),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .count    (count),
        .group    (group),
        .load_err (load_err)
    );

    flashprog_optimer #(.TW(TW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .dur    (dur),
        .tick   (osc_tick),
        .expire (tmr_expire)
    );

    // State register and control-field updates
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            op_q    <= OP_NONE;
            abort_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (ctl_wr) begin
                        op_q <= op_req;
                        if (reject)
                            abort_q <= 1'b1;
                        else if (!launch_req && reg_wdata[CTL_ABORT])
                            abort_q <= 1'b0;
                    end
                    if (launch) begin
                        idx   <= '0;
                        state <= (op_req == OP_ROW) ? ST_STREAM : ST_ISSUE;
                    end
                end
                ST_STREAM: begin
                    idx <= idx + 1'b1;
                    if (idx == IW'(ROW_WORDS - 1))
                        state <= ST_WAIT;
                end
                ST_ISSUE:  state <= ST_WAIT;
                ST_WAIT:   if (tmr_expire) state <= ST_FINISH;
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        fl_row_prog   = 1'b0;
        fl_page_erase = 1'b0;
        fl_word_prog  = 1'b0;
        fl_addr       = '0;
        fl_wdata      = '0;
        tmr_start     = 1'b0;
        op_done       = 1'b0;
        fin_flush     = 1'b0;
        unique case (state)
            ST_STREAM: begin
                fl_row_prog = 1'b1;
                fl_addr     = to_byte({group, idx});
                fl_wdata    = rd_data;
                tmr_start   = (idx == IW'(ROW_WORDS - 1));
            end
            ST_ISSUE: begin
                tmr_start = 1'b1;
                if (op_q == OP_PAGE) begin
                    fl_page_erase = 1'b1;
                    fl_addr       = to_byte({group[GW-1:PW], (PW+IW)'(0)});
                end else begin
                    fl_word_prog = 1'b1;
                    fl_addr      = to_byte({group, last_idx});
                    fl_wdata     = rd_data;
                end
            end
            ST_FINISH: begin
                op_done   = 1'b1;
                fin_flush = 1'b1;
            end
            default: ;
        endcase
    end

    assign cpu_stall = (state != ST_IDLE);
    assign ctl_rdata = {cpu_stall, 1'b0, load_err, abort_q, 10'b0, op_q};
endmodule

// File: rtl/flashprog_ctrl_chk.sv
module flashprog_ctrl_chk #(
    parameter int FAW = 17
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cpu_stall,
    input logic           op_done,
    input logic           armed,
    input logic [15:0]    ctl_rdata,
    input logic [FAW-1:0] fl_addr,
    input logic           fl_row_prog,
    input logic           fl_page_erase,
    input logic           fl_word_prog
);
    p_strobe_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fl_row_prog, fl_page_erase, fl_word_prog}));

    p_strobe_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_row_prog || fl_page_erase || fl_word_prog) |-> cpu_stall);

    p_start_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_stall) |-> $past(armed));

    p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !cpu_stall);

    p_row_stride_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_row_prog && $past(fl_row_prog)) |-> (fl_addr == $past(fl_addr) + FAW'(3)));

    p_row_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_row_prog) |-> !ctl_rdata[13]);

    p_erase_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fl_page_erase |=> !fl_page_erase);
endmodule

bind flashprog_ctrl flashprog_ctrl_chk #(.FAW(WORD_AW + 2)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_stall     (cpu_stall),
    .op_done       (op_done),
    .armed         (key_armed),
    .ctl_rdata     (ctl_rdata),
    .fl_addr       (fl_addr),
    .fl_row_prog   (fl_row_prog),
    .fl_page_erase (fl_page_erase),
    .fl_word_prog  (fl_word_prog)
);

// File: tb/flashprog_ctrl_tb_top.sv
module flashprog_ctrl_tb_top;
    localparam int WORD_AW    = 15;
    localparam int ROW_TICKS  = 11064;
    localparam int PAGE_TICKS = 9000;
    localparam int WORD_TICKS = 2500;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_wr = 1'b0, reg_sel = 1'b0;
    logic [15:0]        reg_wdata = '0;
    logic [15:0]        ctl_rdata;
    logic               buf_we = 1'b0;
    logic [WORD_AW-1:0] buf_waddr = '0;
    logic [23:0]        buf_wdata = '0;
    logic               osc_tick = 1'b0;
    logic               cpu_stall, op_done;
    logic [WORD_AW+1:0] fl_addr;
    logic [23:0]        fl_wdata;
    logic               fl_row_prog, fl_page_erase, fl_word_prog;

    int vectors = 0, miscompares = 0;
    int dones = 0, row_strobes = 0, page_strobes = 0, word_strobes = 0;
    logic [7:0] fmem [int];

    always #10 clk = ~clk;
    always @(negedge clk) osc_tick <= ~osc_tick;

    flashprog_ctrl #(.WORD_AW(WORD_AW), .ROW_TICKS(ROW_TICKS),
                     .PAGE_TICKS(PAGE_TICKS), .WORD_TICKS(WORD_TICKS)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctl_rdata(ctl_rdata), .buf_we(buf_we),
        .buf_waddr(buf_waddr), .buf_wdata(buf_wdata), .osc_tick(osc_tick),
        .cpu_stall(cpu_stall), .op_done(op_done), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_row_prog(fl_row_prog),
        .fl_page_erase(fl_page_erase), .fl_word_prog(fl_word_prog));

    // Behavioural byte-addressed flash model
    always @(posedge clk) begin
        if (op_done) dones++;
        if (fl_row_prog || fl_word_prog) begin
            fmem[int'(fl_addr)]     = fl_wdata[7:0];
            fmem[int'(fl_addr) + 1] = fl_wdata[15:8];
            fmem[int'(fl_addr) + 2] = fl_wdata[23:16];
            if (fl_row_prog) row_strobes++; else word_strobes++;
        end
        if (fl_page_erase) begin
            page_strobes++;
            for (int i = 0; i < 1536; i++) fmem[int'(fl_addr) + i] = 8'hFF;
        end
    end

    function automatic logic [7:0] rd_byte(input int a);
        return fmem.exists(a) ? fmem[a] : 8'hFF;
    endfunction

    function automatic logic [23:0] rd_word(input int w);
        return {rd_byte(3*w + 2), rd_byte(3*w + 1), rd_byte(3*w)};
    endfunction

    function automatic logic [23:0] pat(input int w);
        return 24'hA00000 ^ 24'(w * 37);
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic load_word(input int w, input logic [23:0] d);
        @(negedge clk);
        buf_we = 1'b1; buf_waddr = WORD_AW'(w); buf_wdata = d;
        @(negedge clk);
        buf_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic unlock_start(input logic [1:0] op);
        reg_write(1'b1, 16'h0055);
        reg_write(1'b1, 16'h00AA);
        reg_write(1'b0, {1'b1, 13'b0, op});
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (cpu_stall) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic expect_quiet(input string tag);
        repeat (3) @(negedge clk);
        check(!cpu_stall && !ctl_rdata[15], tag, int'(ctl_rdata), 0);
    endtask

    task automatic t_reset();
        check(ctl_rdata == 16'h0000, "R1 ctl reset", int'(ctl_rdata), 0);
        check(!cpu_stall && !fl_row_prog && !fl_page_erase && !fl_word_prog,
              "R1 outputs idle", int'(cpu_stall), 0);
    endtask

    task automatic t_broken_unlock();
        for (int i = 0; i < 64; i++) load_word(320 + i, pat(320 + i));
        check(!ctl_rdata[13], "R4 clean fill", int'(ctl_rdata[13]), 0);
        reg_write(1'b0, 16'h8001);
        expect_quiet("R3 start without key");
        reg_write(1'b1, 16'h0055); reg_write(1'b0, 16'h0001);
        reg_write(1'b1, 16'h00AA); reg_write(1'b0, 16'h8001);
        expect_quiet("R3 control write between keys");
        reg_write(1'b1, 16'h0055); reg_write(1'b1, 16'h0012);
        reg_write(1'b1, 16'h00AA); reg_write(1'b0, 16'h8001);
        expect_quiet("R3 other value between keys");
        reg_write(1'b1, 16'h00AA); reg_write(1'b1, 16'h0055);
        reg_write(1'b0, 16'h8001);
        expect_quiet("R3 keys reversed");
        check(row_strobes == 0 && !ctl_rdata[12], "R3 no strobe no flag", row_strobes, 0);
    endtask

    task automatic t_row_program();
        int cyc, d0, bad;
        d0 = dones;
        unlock_start(2'b01);
        check(ctl_rdata[15] && cpu_stall, "R9 busy visible", int'(ctl_rdata), 16'h8001);
        wait_idle(cyc);
        check(cyc >= 64 + 2*ROW_TICKS - 3 && cyc <= 64 + 2*ROW_TICKS + 3,
              "R9 row stall length", cyc, 64 + 2*ROW_TICKS);
        check(dones == d0 + 1, "R9 one done pulse", dones - d0, 1);
        check(!ctl_rdata[15], "R9 start bit self-clears", int'(ctl_rdata[15]), 0);
        check(row_strobes == 64, "R6 row strobe count", row_strobes, 64);
        bad = 0;
        for (int i = 0; i < 64; i++) if (rd_word(320 + i) != pat(320 + i)) bad++;
        check(bad == 0, "R6 row contents", bad, 0);
        check(rd_byte(959) == 8'hFF && rd_byte(1152) == 8'hFF, "R6 row bounds",
              int'({rd_byte(959), rd_byte(1152)}), 16'hFFFF);
    endtask

    task automatic t_buffer_reset();
        load_word(20*64, pat(1));
        load_word(20*64 + 1, pat(2));
        check(!ctl_rdata[13], "R11 new group accepted", int'(ctl_rdata[13]), 0);
        unlock_start(2'b01);
        repeat (2) @(negedge clk);
        check(ctl_rdata[12] && !cpu_stall, "R5 partial row refused", int'(ctl_rdata), 16'h1001);
        reg_write(1'b0, 16'h3000);
        check(ctl_rdata == 16'h0000, "R5 flags cleared", int'(ctl_rdata), 0);
    endtask

    task automatic t_load_errors();
        int rs;
        load_word(64*3 + 1, pat(5));
        check(ctl_rdata[13], "R4 skipped slot", int'(ctl_rdata[13]), 1);
        load_word(64*3, pat(6));
        check(ctl_rdata[13], "R4 sticky", int'(ctl_rdata[13]), 1);
        reg_write(1'b0, 16'h2000);
        check(!ctl_rdata[13], "R4 cleared", int'(ctl_rdata[13]), 0);
        load_word(7*64, pat(7));
        load_word(8*64 + 1, pat(8));
        check(ctl_rdata[13], "R4 group change", int'(ctl_rdata[13]), 1);
        rs = row_strobes;
        unlock_start(2'b11);
        repeat (2) @(negedge clk);
        check(ctl_rdata[12] && !cpu_stall && row_strobes == rs && word_strobes == 0,
              "R5 refused on load error", int'(ctl_rdata), 16'h3003);
        reg_write(1'b0, 16'h3000);
        check(ctl_rdata == 16'h0000, "R4 R5 clear", int'(ctl_rdata), 0);
    endtask

    task automatic t_page_erase();
        int cyc;
        fmem[3071] = 8'h00; fmem[3072] = 8'h00; fmem[3500] = 8'h00;
        fmem[4607] = 8'h00; fmem[4608] = 8'h00;
        load_word(17*64, pat(9));
        unlock_start(2'b10);
        wait_idle(cyc);
        check(cyc >= 2 + 2*PAGE_TICKS - 3 && cyc <= 2 + 2*PAGE_TICKS + 3,
              "R9 page stall length", cyc, 2 + 2*PAGE_TICKS);
        check(page_strobes == 1, "R7 one erase strobe", page_strobes, 1);
        check(rd_byte(3072) == 8'hFF && rd_byte(3500) == 8'hFF && rd_byte(4607) == 8'hFF,
              "R7 page erased", int'(rd_byte(3072)), 8'hFF);
        check(rd_byte(3071) == 8'h00 && rd_byte(4608) == 8'h00, "R7 page bounds",
              int'({rd_byte(3071), rd_byte(4608)}), 0);
    endtask

    task automatic t_word_program();
        int cyc;
        for (int i = 0; i < 3; i++) load_word(9*64 + i, pat(100 + i));
        unlock_start(2'b11);
        wait_idle(cyc);
        check(cyc >= 2 + 2*WORD_TICKS - 3 && cyc <= 2 + 2*WORD_TICKS + 3,
              "R9 word stall length", cyc, 2 + 2*WORD_TICKS);
        check(word_strobes == 1, "R8 one word strobe", word_strobes, 1);
        check(rd_word(578) == pat(102), "R8 last word written", int'(rd_word(578)), int'(pat(102)));
        check(rd_byte(1728) == 8'hFF && rd_byte(1737) == 8'hFF, "R8 neighbours untouched",
              int'({rd_byte(1728), rd_byte(1737)}), 16'hFFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_broken_unlock();
        t_row_program();
        t_buffer_reset();
        t_load_errors();
        t_page_erase();
        t_word_program();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule